// File: doc/BRIEF.md
# Overcurrent fault and enable supervisor

This block watches over a half-bridge gate driver. It takes three plain control inputs: a raw overcurrent comparator bit, a flag that the low-side supply is good, and an external active-high enable. It produces two outputs. The first is a registered global kill that blanks the gate-enable outputs of the deadtime controller. The second is a pull-low request for the shared active-low open-drain fault line.

The overcurrent bit must persist for a set number of cycles before it counts as a trip. A trip is latched, and the latch stays set for a fixed hold time after the filtered condition has gone away. A supply dip has to persist for its own filter time before it counts as undervoltage. Undervoltage is not latched: it clears on the first cycle the supply is good again. The block comes out of reset in the undervoltage state, so the fault line stays low through power-up.

All durations are parameters in clock cycles. Reset clears the overcurrent latch and every counter. The interface is control-only: there is no data stream and there is no handshake.

Top module: `hb_fault_sup`

## Requirements
- R1: During reset and after it, until `vdd_good` is first sampled high, `flt_pull` = 1 and `gate_kill` = 1.
- R2: If `ovc_sense` is high for fewer than OC_FILT_CYC consecutive rising edges, neither `flt_pull` nor `gate_kill` changes.
- R3: If `ovc_sense` is high for OC_FILT_CYC consecutive edges, `flt_pull` rises on the (OC_FILT_CYC+1)-th edge, counted from the first edge that samples the bit high.
- R4: `gate_kill` is set on the edge after any edge that leaves `flt_pull` asserted.
- R5: After the trip condition ends, `flt_pull` falls on the (OC_HOLD_CYC+1)-th edge, counted from the first edge that samples `ovc_sense` low (if no other fault is present).
- R6: A new accepted trip during the hold time keeps `flt_pull` asserted, and the hold restarts when that trip ends.
- R7: `vdd_good` low for fewer than UV_FILT_CYC consecutive edges is ignored. Low for UV_FILT_CYC consecutive edges raises `flt_pull` on the UV_FILT_CYC-th edge.
- R8: An undervoltage fault clears on the first edge that samples `vdd_good` high, with no hold time.
- R9: `drv_en` low sets `gate_kill` on the next edge and leaves `flt_pull` unchanged.
- R10: With `drv_en` high and `flt_pull` clear, `gate_kill` is clear after the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ovc_sense | input | 1 | Raw overcurrent comparator bit, 1 = over threshold |
| vdd_good | input | 1 | Low-side supply in range, 1 = good |
| drv_en | input | 1 | External enable, 1 = run, 0 = shut down |
| gate_kill | output | 1 | 1 = force both gate outputs low (registered) |
| flt_pull | output | 1 | 1 = pull the open-drain fault line low |

## Verification
On every cycle, the assertions check the following:
- a filter output only rises after its input has been present for the full persistence count;
- a filter output drops on the edge after its input goes away;
- the latch sets on an accepted trip and falls only after exactly the hold count of quiet samples;
- the kill follows a fault or a disable by one edge, and clears when the block is enabled and fault-free.

Only the bench scenarios show the absolute cycle positions measured from stimulus, the power-up fault, the rejection of short pulses and short dips, and the restart of the hold after a repeat trip.

// File: rtl/hbf_pkg.sv
package hbf_pkg;
  // Bits needed to hold a count from 0 to n inclusive.
  function automatic int cnt_width(int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/hbf_persist.sv
// Persistence filter: q sets after N consecutive samples of raw=1 and
// clears on the first sample of raw=0. INIT chooses the reset value.
module hbf_persist #(
  parameter int N    = 8,
  parameter bit INIT = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic q
);
  localparam int W = hbf_pkg::cnt_width(N);

  logic [W-1:0] cnt;
  logic         q_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      q_r <= INIT;
    end else if (!raw) begin
      cnt <= '0;
      q_r <= 1'b0;
    end else if (!q_r) begin
      if (cnt == W'(N - 1)) begin
        q_r <= 1'b1;
        cnt <= '0;
      end else begin
        cnt <= cnt + W'(1);
      end
    end
  end

  assign q = q_r;

  // Checker: run length of raw, saturating at N.
  logic [W:0] run;
  always_ff @(posedge clk) begin
    if (!rst_n) run <= '0;
    else if (!raw) run <= '0;
    else if (run < (W+1)'(N)) run <= run + (W+1)'(1);
  end

  // R2 / R7: no acceptance before the full persistence count
  p_min_persist_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(q) |-> (run >= (W+1)'(N)));
  // R8: the output drops right after the input goes away
  p_release_now_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !raw |=> !q);
endmodule

// File: rtl/hbf_hold.sv
// Trip latch with a post-condition hold of HOLD cycles.
module hbf_hold #(
  parameter int HOLD = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trip,
  output logic latched
);
  localparam int W = hbf_pkg::cnt_width(HOLD);

  logic [W-1:0] hc;
  logic         lat;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lat <= 1'b0;
      hc  <= '0;
    end else if (trip) begin
      lat <= 1'b1;
      hc  <= '0;
    end else if (lat) begin
      if (hc == W'(HOLD - 1)) begin
        lat <= 1'b0;
        hc  <= '0;
      end else begin
        hc <= hc + W'(1);
      end
    end
  end

  assign latched = lat;

  // Checker: quiet samples since the trip ended, saturating at HOLD.
  logic [W-1:0] gap;
  always_ff @(posedge clk) begin
    if (!rst_n) gap <= '0;
    else if (trip) gap <= '0;
    else if (gap < W'(HOLD)) gap <= gap + W'(1);
  end

  // R3 / R6: an accepted trip sets (or keeps) the latch
  p_trip_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    trip |=> lat);
  // R5: the latch falls only after exactly HOLD quiet samples
  p_hold_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lat) |-> (gap == W'(HOLD)));
  // R6: the latch never falls while a trip is present
  p_no_drop_in_trip_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lat) |-> !$past(trip));
endmodule

// File: rtl/hb_fault_sup.sv
module hb_fault_sup #(
  parameter int OC_FILT_CYC = 450,
  parameter int OC_HOLD_CYC = 57500,
  parameter int UV_FILT_CYC = 375
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ovc_sense,
  input  logic vdd_good,
  input  logic drv_en,
  output logic gate_kill,
  output logic flt_pull
);
  logic oc_trip;
  logic oc_lat;
  logic uv_flt;
  logic vdd_bad;
  logic kill_r;

  assign vdd_bad = ~vdd_good;

  hbf_persist #(.N(OC_FILT_CYC), .INIT(1'b0)) u_oc_filt (
    .clk(clk), .rst_n(rst_n), .raw(ovc_sense), .q(oc_trip));

  // Undervoltage starts asserted so power-up reports a fault.
  hbf_persist #(.N(UV_FILT_CYC), .INIT(1'b1)) u_uv_filt (
    .clk(clk), .rst_n(rst_n), .raw(vdd_bad), .q(uv_flt));

  hbf_hold #(.HOLD(OC_HOLD_CYC)) u_oc_hold (
    .clk(clk), .rst_n(rst_n), .trip(oc_trip), .latched(oc_lat));

  assign flt_pull = uv_flt | oc_lat;

  always_ff @(posedge clk) begin
    if (!rst_n) kill_r <= 1'b1;
    else        kill_r <= ~drv_en | flt_pull;
  end

  assign gate_kill = kill_r;

  // R4: any fault kills the gates on the next edge
  p_kill_on_fault_r4: assert property (@(posedge clk) disable iff (!rst_n)
    flt_pull |=> gate_kill);
  // R9: disable kills the gates on the next edge
  p_kill_on_disable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !drv_en |=> gate_kill);
  // R10: enabled and fault-free lets the gates run
  p_run_when_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_en && !flt_pull) |=> !gate_kill);
endmodule

// File: tb/test_hb_fault_sup.sv
module test_hb_fault_sup;
  localparam int OCF  = 8;
  localparam int HOLD = 40;
  localparam int UVF  = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ovc_sense = 1'b0;
  logic vdd_good = 1'b0;
  logic drv_en = 1'b0;
  logic gate_kill, flt_pull;

  always #2 clk = ~clk;  // 250 MHz

  hb_fault_sup #(.OC_FILT_CYC(OCF), .OC_HOLD_CYC(HOLD), .UV_FILT_CYC(UVF))
    i_hb_fault_sup (.clk(clk), .rst_n(rst_n), .ovc_sense(ovc_sense),
      .vdd_good(vdd_good), .drv_en(drv_en), .gate_kill(gate_kill),
      .flt_pull(flt_pull));

  typedef struct {
    int    cyc;
    bit    sel;   // 0 = gate_kill, 1 = flt_pull
    bit    val;
    string req;
  } exp_t;

  exp_t sb[$];
  int cyc = 0;
  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // Driver side: queue an expectation for the negedge after edge c.
  function automatic void expect_at(int c, bit sel, bit v, string req);
    exp_t e;
    e.cyc = c; e.sel = sel; e.val = v; e.req = req;
    sb.push_back(e);
  endfunction

  task automatic wait_neg(int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: pops and compares items that fall due.
  always @(negedge clk) begin
    for (int i = sb.size() - 1; i >= 0; i--) begin
      if (sb[i].cyc == cyc) begin
        bit act;
        act = sb[i].sel ? flt_pull : gate_kill;
        n_checks++;
        if (act !== sb[i].val) begin
          n_fail++;
          $display("FAIL %s cycle %0d %s actual=%0b expected=%0b", sb[i].req,
                   cyc, sb[i].sel ? "flt_pull" : "gate_kill", act, sb[i].val);
        end
        sb.delete(i);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int t;
    // R1: reset state
    expect_at(2, 1'b0, 1'b1, "R1");
    expect_at(2, 1'b1, 1'b1, "R1");
    wait_neg(4);
    rst_n = 1'b1;
    // R1: power-up undervoltage remains while supply not yet good
    expect_at(8, 1'b1, 1'b1, "R1");
    expect_at(8, 1'b0, 1'b1, "R1");
    wait_neg(6);
    t = cyc;
    vdd_good = 1'b1;
    expect_at(t + 1, 1'b1, 1'b0, "R8");
    expect_at(t + 2, 1'b0, 1'b1, "R9");   // still disabled
    wait_neg(4);
    t = cyc;
    drv_en = 1'b1;
    expect_at(t + 1, 1'b0, 1'b0, "R10");
    wait_neg(4);

    // R2: pulse one sample short of the filter
    t = cyc;
    ovc_sense = 1'b1;
    wait_neg(OCF - 1);
    ovc_sense = 1'b0;
    expect_at(t + OCF, 1'b1, 1'b0, "R2");
    expect_at(t + OCF + 2, 1'b1, 1'b0, "R2");
    expect_at(t + OCF + 2, 1'b0, 1'b0, "R2");
    wait_neg(OCF + 4);

    // R3 / R4: accepted trip
    t = cyc;
    ovc_sense = 1'b1;
    expect_at(t + OCF, 1'b1, 1'b0, "R3");
    expect_at(t + OCF + 1, 1'b1, 1'b1, "R3");
    expect_at(t + OCF + 1, 1'b0, 1'b0, "R4");
    expect_at(t + OCF + 2, 1'b0, 1'b1, "R4");
    wait_neg(20);
    // R5: hold after release
    t = cyc;
    ovc_sense = 1'b0;
    expect_at(t + HOLD, 1'b1, 1'b1, "R5");
    expect_at(t + HOLD + 1, 1'b1, 1'b0, "R5");
    expect_at(t + HOLD + 1, 1'b0, 1'b1, "R5");
    expect_at(t + HOLD + 2, 1'b0, 1'b0, "R10");
    wait_neg(HOLD + 6);

    // R6: repeat trip during hold restarts it
    ovc_sense = 1'b1;
    wait_neg(OCF + 6);
    t = cyc;
    ovc_sense = 1'b0;
    expect_at(t + HOLD + 5, 1'b1, 1'b1, "R6");
    wait_neg(10);
    ovc_sense = 1'b1;
    wait_neg(OCF + 10);
    t = cyc;
    ovc_sense = 1'b0;
    expect_at(t + HOLD, 1'b1, 1'b1, "R6");
    expect_at(t + HOLD + 1, 1'b1, 1'b0, "R6");
    wait_neg(HOLD + 6);

    // R7: short supply dip ignored
    t = cyc;
    vdd_good = 1'b0;
    wait_neg(UVF - 1);
    vdd_good = 1'b1;
    expect_at(t + UVF, 1'b1, 1'b0, "R7");
    expect_at(t + UVF + 1, 1'b0, 1'b0, "R7");
    wait_neg(UVF + 4);
    // R7: long dip accepted
    t = cyc;
    vdd_good = 1'b0;
    expect_at(t + UVF - 1, 1'b1, 1'b0, "R7");
    expect_at(t + UVF, 1'b1, 1'b1, "R7");
    expect_at(t + UVF + 1, 1'b0, 1'b1, "R7");
    wait_neg(UVF + 10);
    // R8: release with no hold
    t = cyc;
    vdd_good = 1'b1;
    expect_at(t + 1, 1'b1, 1'b0, "R8");
    expect_at(t + 2, 1'b0, 1'b0, "R8");
    wait_neg(5);

    // R9: enable low
    t = cyc;
    drv_en = 1'b0;
    expect_at(t + 1, 1'b0, 1'b1, "R9");
    expect_at(t + 1, 1'b1, 1'b0, "R9");
    wait_neg(3);
    drv_en = 1'b1;
    expect_at(t + 4, 1'b0, 1'b0, "R10");
    wait_neg(5);

    if (sb.size() != 0) begin
      n_fail++;
      $display("FAIL scoreboard actual=%0d pending expected=0", sb.size());
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule